// File: doc/BRIEF.md
# Non-Maskable and Maskable Interrupt Take Unit

This block sits between the asynchronous interrupt pins of a processor core model and its instruction sequencer. It accepts two raw requests. The first is a level-held maskable request. The second is a non-maskable request that acts on its rising edge. Both raw requests are brought into the core clock domain through a synchronizer chain.

The sequencer pulses an instruction-boundary strobe each time an instruction retires. At that point the unit decides whether to divert control. A non-maskable take carries a fixed vector and needs no external acknowledge. A maskable take is gated by the core's interrupt-enable flag. It opens exactly one acknowledge cycle, which stays requested until the bus side reports it done.

Non-maskable service is tracked internally. An edge that arrives while a handler is running is held as a single pending request. That request is released only after the return-from-interrupt pulse, and any further edges in that window are dropped.

Top module: `irq_take_unit`

## Requirements
- R1: After reset, take_nmi, take_intr and ack_req are 0 and take_vector is 0.
- R2: A rising edge on nmi_raw is latched, and the next instruction boundary produces a one-cycle take_nmi with take_vector equal to NMI_VECTOR (default 2). ack_req does not rise for this take.
- R3: Holding nmi_raw high counts as a single edge. After its service ends, no further non-maskable take occurs while the level stays high.
- R4: While a non-maskable handler is in service (from its take until an iret_pulse), no take_nmi occurs. An edge seen in that window is taken at the first boundary after iret_pulse.
- R5: At most one edge is held pending. Any further edges before the pending one is taken are discarded.
- R6: take_intr fires only at a boundary where the synchronized irq_raw is 1 and irq_enable is 1. On that take, take_vector is 0.
- R7: A maskable take raises ack_req, which stays 1 until ack_done. No further take_intr occurs while ack_req is 1.
- R8: When both requests are eligible at the same boundary, only take_nmi fires. The maskable request remains eligible for a later boundary.
- R9: Without insn_boundary, neither take output fires, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_raw | input | 1 | Asynchronous maskable request, level-held |
| nmi_raw | input | 1 | Asynchronous non-maskable request, rising-edge sensitive |
| insn_boundary | input | 1 | Instruction-retire strobe |
| irq_enable | input | 1 | Core interrupt-enable flag |
| iret_pulse | input | 1 | Return-from-interrupt strobe; ends non-maskable service |
| ack_done | input | 1 | Acknowledge cycle completed |
| take_nmi | output | 1 | One-cycle non-maskable take |
| take_intr | output | 1 | One-cycle maskable take |
| take_vector | output | VEC_W | Vector for the current take (NMI_VECTOR, else 0) |
| ack_req | output | 1 | Acknowledge cycle requested |

## Verification
The hardest situation to reach from the ports is a pending edge that must survive a handler and then must not be duplicated. The stimulus first takes a non-maskable request with nmi_raw held high. During service it toggles the raw pin twice and strobes a boundary to show the take is blocked. It then returns and expects exactly one extra take, followed by none while the level is still high. A second hard situation is a boundary that arrives while an acknowledge is still open with the maskable request held. Reaching it requires keeping ack_done low across a full boundary.

// File: rtl/irq_take_pkg.sv
package irq_take_pkg;
   typedef struct packed {
      logic nmi;
      logic intr;
   } take_t;

   localparam int unsigned RAW_NMI = 0;
   localparam int unsigned RAW_IRQ = 1;
   localparam int unsigned RAW_CNT = 2;
endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stage_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= 1'b0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= 1'b0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_nmi_tracker.sv
module irq_nmi_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic take,
   input  logic iret,
   output logic ready,
   output logic in_service
);
   logic prev_q, pend_q, svc_q;
   logic edge_seen;

   assign edge_seen = lvl & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         svc_q  <= 1'b0;
      end else begin
         prev_q <= lvl;
         pend_q <= (pend_q & ~take) | edge_seen;
         svc_q  <= take | (svc_q & ~iret);
      end
   end

   assign ready      = pend_q & ~svc_q;
   assign in_service = svc_q;
endmodule

// File: rtl/irq_mask_tracker.sv
module irq_mask_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic enable,
   input  logic take,
   input  logic done,
   output logic ready,
   output logic busy
);
   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= take | (busy_q & ~done);
   end

   assign ready = lvl & enable & ~busy_q;
   assign busy  = busy_q;
endmodule

// File: rtl/irq_take_unit.sv
module irq_take_unit
   import irq_take_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned NMI_VECTOR  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_raw,
   input  logic             nmi_raw,
   input  logic             insn_boundary,
   input  logic             irq_enable,
   input  logic             iret_pulse,
   input  logic             ack_done,
   output logic             take_nmi,
   output logic             take_intr,
   output logic [VEC_W-1:0] take_vector,
   output logic             ack_req
);
   localparam logic [VEC_W-1:0] NMI_VEC_L = VEC_W'(NMI_VECTOR);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (VEC_W < 2 || VEC_W > 16) begin : g_bad_width
      $error("VEC_W out of range");
   end
   if (NMI_VECTOR >= (1 << VEC_W)) begin : g_bad_vec
      $error("NMI_VECTOR does not fit VEC_W");
   end

   logic [RAW_CNT-1:0] raw_in, raw_sync;
   assign raw_in[RAW_NMI] = nmi_raw;
   assign raw_in[RAW_IRQ] = irq_raw;

   for (genvar i = 0; i < RAW_CNT; i++) begin : g_sync
      irq_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw_in[i]),
         .q     (raw_sync[i])
      );
   end

   logic  nmi_ready, nmi_in_service, mask_ready, mask_busy;
   take_t take_d, take_q;

   always_comb begin
      take_d.nmi  = insn_boundary & nmi_ready;
      take_d.intr = insn_boundary & mask_ready & ~nmi_ready;
   end

   irq_nmi_tracker u_nmi (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl        (raw_sync[RAW_NMI]),
      .take       (take_d.nmi),
      .iret       (iret_pulse),
      .ready      (nmi_ready),
      .in_service (nmi_in_service)
   );

   irq_mask_tracker u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (raw_sync[RAW_IRQ]),
      .enable (irq_enable),
      .take   (take_d.intr),
      .done   (ack_done),
      .ready  (mask_ready),
      .busy   (mask_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) take_q <= '0;
      else        take_q <= take_d;
   end

   assign take_nmi    = take_q.nmi;
   assign take_intr   = take_q.intr;
   assign take_vector = take_q.nmi ? NMI_VEC_L : '0;
   assign ack_req     = mask_busy;
endmodule

// File: rtl/irq_take_unit_chk.sv
module irq_take_unit_chk #(
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned NMI_VECTOR = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             insn_boundary,
   input logic             irq_enable,
   input logic             iret_pulse,
   input logic             ack_done,
   input logic             take_nmi,
   input logic             take_intr,
   input logic [VEC_W-1:0] take_vector,
   input logic             ack_req,
   input logic             nmi_in_service
);
   p_one_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_nmi && take_intr));

   p_take_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (take_nmi || take_intr) |-> $past(insn_boundary));

   p_nmi_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take_nmi |-> (take_vector == VEC_W'(NMI_VECTOR)) && !$rose(ack_req));

   p_intr_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_intr |-> $past(irq_enable) && (take_vector == '0));

   p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !ack_done) |=> ack_req);

   p_no_intr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_intr |-> !$past(ack_req));

   p_no_nmi_in_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take_nmi |-> !$past(nmi_in_service));

   p_service_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_in_service && !iret_pulse) |=> nmi_in_service);
endmodule

bind irq_take_unit irq_take_unit_chk #(.VEC_W(VEC_W), .NMI_VECTOR(NMI_VECTOR)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .insn_boundary  (insn_boundary),
   .irq_enable     (irq_enable),
   .iret_pulse     (iret_pulse),
   .ack_done       (ack_done),
   .take_nmi       (take_nmi),
   .take_intr      (take_intr),
   .take_vector    (take_vector),
   .ack_req        (ack_req),
   .nmi_in_service (nmi_in_service)
);

// File: tb/tb_irq_take_unit.sv
`timescale 1ns/1ps
module tb_irq_take_unit;
   localparam int VW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_raw = 1'b0, nmi_raw = 1'b0, insn_boundary = 1'b0;
   logic irq_enable = 1'b0, iret_pulse = 1'b0, ack_done = 1'b0;
   logic take_nmi, take_intr, ack_req;
   logic [VW-1:0] take_vector;

   int total = 0;
   int fails = 0;

   always #4 clk = ~clk;

   irq_take_unit #(.SYNC_STAGES(2), .VEC_W(VW), .NMI_VECTOR(2)) dut (
      .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .nmi_raw(nmi_raw),
      .insn_boundary(insn_boundary), .irq_enable(irq_enable),
      .iret_pulse(iret_pulse), .ack_done(ack_done), .take_nmi(take_nmi),
      .take_intr(take_intr), .take_vector(take_vector), .ack_req(ack_req)
   );

   // row fields: {nmi_pulse, irq_level, enable, exp_nmi, exp_intr}
   localparam logic [4:0] ROWS [6] = '{
      5'b10010,   // R2: lone edge
      5'b01101,   // R6: enabled maskable
      5'b01000,   // R6: masked
      5'b11110,   // R8: both eligible, NMI wins
      5'b00100,   // R9-style idle boundary
      5'b11010    // R2: edge with masked level
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe_boundary();
      insn_boundary = 1'b1;
      @(negedge clk);
      insn_boundary = 1'b0;
   endtask

   task automatic pulse_iret();
      iret_pulse = 1'b1;
      @(negedge clk);
      iret_pulse = 1'b0;
   endtask

   task automatic pulse_ack();
      ack_done = 1'b1;
      @(negedge clk);
      ack_done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int seen;
      idle(3);
      chk("R1 take_nmi", take_nmi, 0);
      chk("R1 take_intr", take_intr, 0);
      chk("R1 ack_req", ack_req, 0);
      chk("R1 take_vector", take_vector, 0);
      rst_n = 1'b1;
      idle(2);

      foreach (ROWS[i]) begin
         nmi_raw    = ROWS[i][4];
         irq_raw    = ROWS[i][3];
         irq_enable = ROWS[i][2];
         idle(4);
         strobe_boundary();
         chk($sformatf("R2/R6/R8 row%0d take_nmi", i), take_nmi, ROWS[i][1]);
         chk($sformatf("R6/R8 row%0d take_intr", i), take_intr, ROWS[i][0]);
         chk($sformatf("R2/R6 row%0d take_vector", i), take_vector, ROWS[i][1] ? 2 : 0);
         chk($sformatf("R2/R7 row%0d ack_req", i), ack_req, ROWS[i][0]);
         nmi_raw = 1'b0; irq_raw = 1'b0; irq_enable = 1'b0;
         idle(3);
         if (ROWS[i][1]) pulse_iret();
         if (ROWS[i][0]) pulse_ack();
         idle(3);
      end

      // R9: no boundary, no take
      irq_raw = 1'b1; irq_enable = 1'b1; nmi_raw = 1'b1;
      seen = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (take_nmi || take_intr) seen++;
      end
      chk("R9 takes without boundary", seen, 0);
      strobe_boundary();
      chk("R8 nmi first", take_nmi, 1);
      chk("R8 intr deferred", take_intr, 0);
      strobe_boundary();
      chk("R8 intr later", take_intr, 1);
      irq_raw = 1'b0; irq_enable = 1'b0;
      pulse_ack();
      pulse_iret();
      idle(2);

      // R3/R4/R5: nmi_raw still high from above; level gives no new take
      strobe_boundary();
      chk("R3 held level", take_nmi, 0);
      nmi_raw = 1'b0; idle(3);
      nmi_raw = 1'b1; idle(4);
      strobe_boundary();
      chk("R2 new edge", take_nmi, 1);
      nmi_raw = 1'b0; idle(3);
      nmi_raw = 1'b1; idle(3);
      nmi_raw = 1'b0; idle(3);
      nmi_raw = 1'b1; idle(3);
      strobe_boundary();
      chk("R4 blocked in service", take_nmi, 0);
      pulse_iret();
      strobe_boundary();
      chk("R4 pending after iret", take_nmi, 1);
      chk("R4 vector", take_vector, 2);
      pulse_iret();
      strobe_boundary();
      chk("R5 extra edge dropped", take_nmi, 0);
      nmi_raw = 1'b0;
      idle(3);

      // R7: single acknowledge per take
      irq_raw = 1'b1; irq_enable = 1'b1;
      idle(4);
      strobe_boundary();
      chk("R7 take", take_intr, 1);
      chk("R7 ack raised", ack_req, 1);
      idle(2);
      strobe_boundary();
      chk("R7 no retake while busy", take_intr, 0);
      chk("R7 ack held", ack_req, 1);
      pulse_ack();
      chk("R7 ack released", ack_req, 0);
      strobe_boundary();
      chk("R7 retake after done", take_intr, 1);
      irq_raw = 1'b0; irq_enable = 1'b0;
      pulse_ack();
      idle(2);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule